// File: doc/BRIEF.md
# Delay Line Phase Tuner

This block drives a tapped delay line that places the sampling edge of a receive clock, and it chooses that placement itself. A sweep starts with a one-cycle `start` pulse and runs in two stages.

The first stage is calibration. The block steps a unit-delay code upward from zero. For each code it enables the delay line in measurement mode and waits for the line to report how many taps one clock period spans. It keeps the first code whose report is usable. From that report it takes the highest tap worth trying.

The second stage is the phase search. Each candidate tap is applied in turn, and an external tester is asked whether a tuning transfer worked at that tap. The block tracks the widest unbroken window of passing taps and places the sampling point at the centre of that window. The block then reports success with `done`. If no calibration code works, or no tap passes, it reports `fail` and leaves the line in clock pass-through.

Top module: `dly_tuner`

## Requirements
- R1: After reset `busy`, `done`, `fail`, `test_req`, `dl_en` and `dl_sample` are all low, which puts the line in clock pass-through.
- R2: `busy` is high from the cycle after an accepted `start` until the cycle in which `done` or `fail` pulses. A `start` that arrives while `busy` is high is ignored.
- R3: During calibration `dl_en`=1, `dl_sample`=1 and `dl_sel`=TAPS+1 (12 by default). `dl_unit` begins at 0 and only ever rises by one.
- R4: Each code spends one settle cycle and then waits. If a report arrives with `dl_len` nonzero and `dl_len` bit TAPS clear (below 2^TAPS), that report is accepted, and the highest tap becomes the index of the most significant set bit of `dl_len`. If a report arrives that fails this test, the block moves to the next code.
- R5: If `dl_len_valid` does not arrive within TIMEOUT_CYC cycles after the settle cycle, the block moves to the next code. A code that times out therefore takes 1+TIMEOUT_CYC cycles, and a code with an unusable report takes 2 cycles.
- R6: If the last code (2^UNIT_W−1) also fails, `fail` pulses and `dl_en`=`dl_sample`=0.
- R7: The phase search tests taps 0 through the highest tap, in increasing order, once each. During each test `test_req` is high, `dl_sel` holds the tap, `dl_en`=1 and `dl_sample`=0. `test_req` stays high until `test_ack`, and `test_pass` is read in the `test_ack` cycle.
- R8: A failing tap resets the current run to zero. A run that becomes strictly longer than the best run so far records its end tap, so a later run of equal length does not displace it. The final tap is that end minus floor(best length / 2).
- R9: If no tap passes, `fail` pulses and `dl_en`=`dl_sample`=0.
- R10: On success there is one cycle with `dl_en`=`dl_sample`=0. After that, `done` pulses for one cycle while `dl_sel` already holds the final tap with `dl_en`=1 and `dl_sample`=0, and these settings are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a sweep (ignored while busy) |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| dl_en | output | 1 | Delay line enable |
| dl_sample | output | 1 | Delay line length-measurement enable |
| dl_sel | output | SEL_W | Tap select |
| dl_unit | output | UNIT_W | Unit-delay code |
| dl_len | input | TAPS+1 | Measured period length in taps (thermometer-like) |
| dl_len_valid | input | 1 | Length report valid |
| test_req | output | 1 | Request one tuning transfer at the current tap |
| test_ack | input | 1 | Tester verdict valid |
| test_pass | input | 1 | Tester verdict: transfer succeeded |

## Verification
The tester's verdict on the highest tap arrives in the same cycle in which the search decides to finish. That last verdict has to be folded into the run before the centre is computed. The bench provokes this with all-pass patterns and with a full sweep of every pass pattern over four taps, many of which end their widest window at the top tap. It judges the outcome by comparing the final `dl_sel` against a centre worked out in the bench. A second `start` is also injected in the middle of a calibration, where it must neither restart the sweep nor produce a second pulse.

// File: rtl/dly_tuner.sv
module dly_tuner #(
  parameter int TAPS        = 11,
  parameter int UNIT_W      = 7,
  parameter int TIMEOUT_CYC = 100000,
  localparam int LEN_W = TAPS + 1,
  localparam int SEL_W = $clog2(TAPS + 2),
  localparam int CNT_W = $clog2(TAPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              dl_en,
  output logic              dl_sample,
  output logic [SEL_W-1:0]  dl_sel,
  output logic [UNIT_W-1:0] dl_unit,
  input  logic [LEN_W-1:0]  dl_len,
  input  logic              dl_len_valid,
  output logic              test_req,
  input  logic              test_ack,
  input  logic              test_pass
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [UNIT_W-1:0] UNIT_LAST = '1;
  localparam logic [SEL_W-1:0]  SEL_MEAS  = SEL_W'(TAPS + 1);

  typedef enum logic [2:0] {S_IDLE, S_LSET, S_LWAIT, S_PTEST, S_PSTEP, S_CLR} st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic [SEL_W-1:0] tap_hi, best_end;
  logic [CNT_W-1:0] cur, best, run_nxt;
  logic             len_ok, better;

  function automatic logic [SEL_W-1:0] top_bit(input logic [LEN_W-1:0] v);
    top_bit = '0;
    for (int i = 0; i < LEN_W; i++)
      if (v[i]) top_bit = SEL_W'(i);
  endfunction

  assign busy     = (st != S_IDLE);
  assign test_req = (st == S_PTEST);
  assign len_ok   = (dl_len != '0) && !dl_len[LEN_W-1];
  assign run_nxt  = test_pass ? cur + 1'b1 : '0;
  assign better   = run_nxt > best;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; tap_hi <= '0; best_end <= '0;
      cur <= '0; best <= '0; done <= 1'b0; fail <= 1'b0;
      dl_en <= 1'b0; dl_sample <= 1'b0; dl_sel <= '0; dl_unit <= '0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            dl_unit <= '0; dl_en <= 1'b1; dl_sample <= 1'b1;
            dl_sel <= SEL_MEAS; st <= S_LSET;
          end
        S_LSET: begin
          tmr <= '0;
          st  <= S_LWAIT;
        end
        S_LWAIT:
          if (dl_len_valid && len_ok) begin
            tap_hi <= top_bit(dl_len);
            dl_sel <= '0; dl_sample <= 1'b0;
            cur <= '0; best <= '0; best_end <= '0;
            st <= S_PTEST;
          end else if (dl_len_valid || tmr == TW'(TIMEOUT_CYC - 1)) begin
            if (dl_unit == UNIT_LAST) begin
              fail <= 1'b1; dl_en <= 1'b0; dl_sample <= 1'b0;
              st <= S_IDLE;
            end else begin
              dl_unit <= dl_unit + 1'b1;
              st <= S_LSET;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        S_PTEST:
          if (test_ack) begin
            cur <= run_nxt;
            if (better) begin
              best <= run_nxt;
              best_end <= dl_sel;
            end
            if (dl_sel == tap_hi) begin
              dl_en <= 1'b0;
              st <= S_CLR;
            end else begin
              dl_sel <= dl_sel + 1'b1;
              st <= S_PSTEP;
            end
          end
        S_PSTEP: st <= S_PTEST;
        S_CLR: begin
          st <= S_IDLE;
          if (best == '0) begin
            fail <= 1'b1;
          end else begin
            dl_sel <= best_end - SEL_W'(best >> 1);
            dl_en <= 1'b1;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_ok_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !test_req);
  p_one_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  p_meas_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LSET || st == S_LWAIT) |-> (dl_en && dl_sample && dl_sel == SEL_MEAS));
  p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LSET && $past(st) == S_LWAIT) |-> dl_unit == $past(dl_unit) + 1'b1);
  p_tmr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LWAIT) |-> tmr < TW'(TIMEOUT_CYC));
  p_fail_safe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!dl_en && !dl_sample && !busy));
  p_tap_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    test_req |-> (dl_en && !dl_sample && dl_sel <= tap_hi));
  p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req && !test_ack) |=> $stable(dl_sel));
  p_run_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PTEST) |-> (cur <= best && {1'b0, best} <= {1'b0, dl_sel}));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dl_en && !dl_sample && !busy && $past(!dl_en)));
endmodule

// File: tb/dly_tuner_test.sv
module dly_tuner_test;
  localparam int TAPS = 11;
  localparam int TMO  = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, fail, dl_en, dl_sample, test_req;
  logic [3:0] dl_sel;
  logic [6:0] dl_unit;
  logic [11:0] dl_len;
  logic dl_len_valid;
  logic test_ack = 1'b0, test_pass = 1'b0;

  int checks = 0, errors = 0;
  int tgt_unit = 0;
  logic [11:0] tgt_len = '0;
  logic [10:0] pat = '0;
  int seen = 0, order_bad = 0, cfg_bad = 0, unit_bad = 0;
  int done_cnt = 0, fail_cnt = 0, clr_ok = 0, ack_wait = 0;
  int prev_unit = 0;
  logic prev_en = 1'b0, prev_smp = 1'b0;
  bit finished = 0;

  always #5 clk = ~clk;

  dly_tuner #(.TAPS(TAPS), .UNIT_W(7), .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
    .dl_en(dl_en), .dl_sample(dl_sample), .dl_sel(dl_sel), .dl_unit(dl_unit),
    .dl_len(dl_len), .dl_len_valid(dl_len_valid), .test_req(test_req),
    .test_ack(test_ack), .test_pass(test_pass));

  // delay line model: codes below the target time out, report zero, or report an overlong length
  always_comb begin
    int u;
    u = int'(dl_unit);
    dl_len_valid = 1'b0;
    dl_len = '0;
    if (dl_sample) begin
      if (u == tgt_unit) begin dl_len_valid = 1'b1; dl_len = tgt_len; end
      else if (u % 3 == 1) begin dl_len_valid = 1'b1; dl_len = 12'h000; end
      else if (u % 3 == 2) begin dl_len_valid = 1'b1; dl_len = 12'h800; end
    end
  end

  always @(negedge clk) begin
    test_ack <= 1'b0;
    if (rst_n && test_req && !test_ack) begin
      if (ack_wait == 2) begin
        test_ack <= 1'b1;
        test_pass <= pat[dl_sel];
        if (int'(dl_sel) != seen) order_bad++;
        seen++;
        ack_wait = 0;
      end else ack_wait++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && dl_sample) begin
        if (dl_sel != 4'd12 || !dl_en) cfg_bad++;
        if (int'(dl_unit) != prev_unit && int'(dl_unit) != prev_unit + 1) unit_bad++;
        prev_unit = int'(dl_unit);
      end
      if (test_req && (dl_sample || !dl_en)) cfg_bad++;
      if (done) begin done_cnt++; if (!prev_en && !prev_smp) clr_ok++; end
      if (fail) fail_cnt++;
      prev_en = dl_en;
      prev_smp = dl_sample;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int msb_of(input logic [11:0] v);
    msb_of = -1;
    for (int i = 0; i < 12; i++) if (v[i]) msb_of = i;
  endfunction

  task automatic run(input int unit_t, input logic [11:0] len_t, input logic [10:0] pat_t,
                     input bit inject);
    int n, first_req, hi, cur, best, bend, fin, exp_n;
    bit ok_exp;
    tgt_unit = unit_t; tgt_len = len_t; pat = pat_t;
    seen = 0; order_bad = 0; cfg_bad = 0; unit_bad = 0;
    done_cnt = 0; fail_cnt = 0; clr_ok = 0; prev_unit = 0; first_req = -1;
    hi = msb_of(len_t);
    cur = 0; best = 0; bend = 0;
    for (int t = 0; t <= hi; t++) begin
      if (pat_t[t]) begin cur++; if (cur > best) begin best = cur; bend = t; end end
      else cur = 0;
    end
    ok_exp = (unit_t < 128) && best > 0;
    fin = bend - best / 2;
    exp_n = 3;
    for (int u = 0; u < unit_t && u < 128; u++) exp_n += (u % 3 == 0) ? 1 + TMO : 2;

    @(negedge clk); start = 1'b1;
    n = 0;
    while (n < 8000) begin
      @(posedge clk); @(negedge clk);
      n++;
      start = (inject && n == 4) ? 1'b1 : 1'b0;
      if (n == 1) chk(busy === 1'b1, "R2 busy after start", busy, 1);
      if (first_req < 0 && test_req) first_req = n;
      if (done || fail) break;
    end
    start = 1'b0;
    chk(busy === 1'b0, "R2 busy low at end", busy, 0);
    chk(cfg_bad == 0 && unit_bad == 0, "R3 measure config and code order", cfg_bad + unit_bad, 0);
    if (unit_t < 128)
      chk(first_req == exp_n, "R4 R5 calibration duration", first_req, exp_n);
    if (ok_exp) begin
      chk(done === 1'b1, "R8 done", done, 1);
      chk(int'(dl_unit) == unit_t, "R4 kept unit code", dl_unit, unit_t);
      chk(seen == hi + 1 && order_bad == 0, "R7 taps tested in order", seen, hi + 1);
      chk(int'(dl_sel) == fin, "R8 centred tap", dl_sel, fin);
      chk(dl_en && !dl_sample, "R10 final enables", {dl_en, dl_sample}, 2);
    end else begin
      chk(fail === 1'b1, unit_t < 128 ? "R9 fail" : "R6 fail", fail, 1);
      chk(!dl_en && !dl_sample, unit_t < 128 ? "R9 pass-through" : "R6 pass-through",
          {dl_en, dl_sample}, 0);
      if (unit_t < 128) chk(seen == hi + 1, "R9 all taps tried", seen, hi + 1);
    end
    repeat (4) @(negedge clk);
    chk(done_cnt + fail_cnt == 1, "R2 R10 single end pulse", done_cnt + fail_cnt, 1);
    if (ok_exp) chk(clr_ok == 1, "R10 clear cycle before done", clr_ok, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !test_req && !dl_en && !dl_sample, "R1 reset state",
        {busy, done, fail, test_req, dl_en, dl_sample}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(0,   12'h400, 11'b000_1111_1000, 0);
    run(5,   12'h00F, 11'b000_0000_1011, 0);
    run(10,  12'h07F, 11'b000_0111_0110, 1);
    run(3,   12'h0FF, 11'b000_0001_1011, 0);
    run(127, 12'h001, 11'b000_0000_0001, 0);
    run(7,   12'h7FF, 11'b111_1111_1111, 0);
    run(2,   12'h03F, 11'b000_0000_0000, 0);
    run(200, 12'h000, 11'b000_0000_0000, 0);
    for (int p = 0; p < 16; p++) run(1, 12'h008, 11'(p), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule